// File: doc/BRIEF.md
# Inter-Processor Message Slot Bank

This block holds a bank of message slots through which a local processor and a peer processor exchange fixed-length messages. Each slot stores one 32-bit control word and a payload of eight 32-bit words. Bits 7:4 of the control word hold a one-hot slot state and bit 0 selects how the peer's acknowledgement is reported. The local processor reaches every word through a plain register port with a word address. It usually changes the state and the acknowledge-mode bit with read-modify-write, so the whole control word is kept exactly as written.

A small peer-side port models the remote core. A receive strobe marks a slot as taken by the peer. An acknowledge strobe completes the slot. In automatic mode the slot falls back to idle, and the sender finds out by polling the state. In interrupt mode the slot moves to the acknowledge state and a one-cycle event is raised on that slot's line of `ack_evt`. A separate interrupt block gathers these events. Once software has handled a message or an acknowledgement, it writes the idle state back to the slot.

Top module: `ipc_mailbox_bank`

## Requirements
- R1: The host port uses word addresses, with bits [8:4] selecting the slot (0 to 31) and bits [3:0] selecting the word inside the slot. Word 0 is the control word and words 1 to 8 are payload words 0 to 7. This equals byte offset 0x40 times the slot plus 4 times the word. A write changes only the addressed word.
- R2: A read request (host_en=1, host_we=0) loads host_rdata at the next rising edge. host_rdata returns the addressed word as it was before that edge, and it keeps its value until the next read request.
- R3: All 32 bits of a control word read back exactly as written. The state codes in bits 7:4 are idle=4'h1, transmit=4'h2, receive=4'h4 and acknowledge=4'h8. Bit 0 set to 1 means automatic acknowledge, and 0 means acknowledge by interrupt.
- R4: After a synchronous reset every control word reads 32'h0000_0010 (idle, interrupt mode), every payload word reads zero and ack_evt is all zero.
- R5: A peer acknowledge on a slot whose stored bit 0 is 1 sets bits 7:4 to idle at that edge, leaves the other bits unchanged and raises no ack_evt.
- R6: A peer acknowledge on a slot whose stored bit 0 is 0 sets bits 7:4 to acknowledge at that edge. The slot's ack_evt bit is then high for exactly the one following cycle.
- R7: A peer receive sets bits 7:4 of that slot to receive and leaves the other bits unchanged.
- R8: Word indices 9 to 15 inside a slot read as zero, and writes to them change no word in the bank.
- R9: When a host control-word write and a peer event hit the same slot at the same edge, the peer's state replaces bits 7:4 and the host data sets all other bits. When a peer acknowledge and a peer receive hit the same slot at the same edge, the acknowledge wins.
- R10: The acknowledge mode applied to a peer acknowledge is the bit 0 value stored before the edge, even if the host writes a new bit 0 at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 9 | Word address: slot in [8:4], word in [3:0] |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |
| peer_ack_valid | input | 1 | Peer acknowledges a slot |
| peer_ack_slot | input | 5 | Slot being acknowledged |
| peer_rx_valid | input | 1 | Peer takes the message in a slot |
| peer_rx_slot | input | 5 | Slot being received |
| ack_evt | output | 32 | One-cycle acknowledge event per slot |

## Verification
Every result appears exactly one edge after its stimulus. Read data, control-word updates from host writes and peer strobes, and the ack_evt pulse are all due at the first rising edge after the inputs are applied. The bench changes inputs on falling edges. A behavioural model updates at each rising edge, and the outputs are compared with it at every falling edge, half a cycle after they settle. The directed checks in each scenario read the affected words one cycle after the event. They also check that ack_evt is high in the cycle after an interrupt-mode acknowledge and low again one cycle later.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int NUM_SLOTS  = 32;
    localparam int DATA_W     = 32;
    localparam int MSG_WORDS  = 8;
    localparam int SLOT_WORDS = 16;

    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int IDX_W  = $clog2(SLOT_WORDS);
    localparam int ADDR_W = SLOT_W + IDX_W;

    localparam int ST_LSB      = 4;
    localparam int ST_W        = 4;
    localparam int ACKMODE_BIT = 0;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 4'h1,
        ST_TX   = 4'h2,
        ST_RX   = 4'h4,
        ST_ACK  = 4'h8
    } slot_state_e;

    localparam logic [DATA_W-1:0] MODE_RST = DATA_W'(32'h0000_0010);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [IDX_W-1:0]  idx;
        logic              is_mode;
        logic              is_data;
    } host_dec_t;

    function automatic host_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        host_dec_t d;
        d.slot    = a[ADDR_W-1:IDX_W];
        d.idx     = a[IDX_W-1:0];
        d.is_mode = (d.idx == '0);
        d.is_data = (d.idx != '0) && (d.idx <= IDX_W'(MSG_WORDS));
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] with_state(input logic [DATA_W-1:0] w,
                                                     input slot_state_e s);
        logic [DATA_W-1:0] r;
        r = w;
        r[ST_LSB +: ST_W] = s;
        return r;
    endfunction

endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
    import mbx_pkg::*;
#(
    parameter int N_SLOTS = mbx_pkg::NUM_SLOTS,
    parameter int N_WORDS = mbx_pkg::MSG_WORDS
) (
    input  logic                             host_en,
    input  logic                             host_we,
    input  logic [ADDR_W-1:0]                host_addr,
    input  logic                             peer_ack_valid,
    input  logic [SLOT_W-1:0]                peer_ack_slot,
    input  logic                             peer_rx_valid,
    input  logic [SLOT_W-1:0]                peer_rx_slot,
    output host_dec_t                        dec,
    output logic                             rd_req,
    output logic [N_SLOTS-1:0]               mode_we,
    output logic [N_SLOTS-1:0][N_WORDS-1:0]  data_we,
    output logic [N_SLOTS-1:0]               ack_vec,
    output logic [N_SLOTS-1:0]               rx_vec
);
    logic wr_req;

    assign dec    = decode_addr(host_addr);
    assign rd_req = host_en && !host_we;
    assign wr_req = host_en && host_we;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        logic hit;
        assign hit        = (dec.slot == SLOT_W'(s));
        assign mode_we[s] = wr_req && hit && dec.is_mode;
        assign ack_vec[s] = peer_ack_valid && (peer_ack_slot == SLOT_W'(s));
        assign rx_vec[s]  = peer_rx_valid && (peer_rx_slot == SLOT_W'(s));
        for (genvar w = 0; w < N_WORDS; w++) begin : g_word
            assign data_we[s][w] = wr_req && hit && dec.is_data
                                   && (dec.idx == IDX_W'(w + 1));
        end
    end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int N_WORDS = mbx_pkg::MSG_WORDS,
    parameter int W       = mbx_pkg::DATA_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mode_we,
    input  logic [N_WORDS-1:0]            data_we,
    input  logic [W-1:0]                  wdata,
    input  logic                          peer_ack,
    input  logic                          peer_rx,
    output logic [W-1:0]                  mode_q,
    output logic [N_WORDS-1:0][W-1:0]     data_q,
    output logic                          ack_evt
);
    logic [W-1:0] mode_d;
    logic         auto_ack;

    assign auto_ack = mode_q[ACKMODE_BIT];

    always_comb begin
        mode_d = mode_q;
        if (mode_we) begin
            mode_d = wdata;
        end
        if (peer_ack) begin
            mode_d = with_state(mode_d, auto_ack ? ST_IDLE : ST_ACK);
        end else if (peer_rx) begin
            mode_d = with_state(mode_d, ST_RX);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RST;
            ack_evt <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            ack_evt <= peer_ack && !auto_ack;
        end
    end

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[w] <= '0;
            end else if (data_we[w]) begin
                data_q[w] <= wdata;
            end
        end
    end

    // R5: automatic-mode acknowledge returns the slot to idle silently
    assert_auto_ack_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (peer_ack && auto_ack) |=> (mode_q[ST_LSB +: ST_W] == ST_IDLE) && !ack_evt);

    // R6: interrupt-mode acknowledge parks the slot and fires the event
    assert_irq_ack_evt_R6: assert property (@(posedge clk) disable iff (rst)
        (peer_ack && !auto_ack) |=> (mode_q[ST_LSB +: ST_W] == ST_ACK) && ack_evt);

    // R6: an event only ever follows an acknowledge
    assert_evt_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
        ack_evt |-> $past(peer_ack));

    // R7: a lone receive strobe marks the slot as received
    assert_rx_state_R7: assert property (@(posedge clk) disable iff (rst)
        (peer_rx && !peer_ack) |=> (mode_q[ST_LSB +: ST_W] == ST_RX));

    // R8/R1: an untouched payload word keeps its value
    assert_payload_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (data_we == '0) |=> $stable(data_q));

endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port
    import mbx_pkg::*;
#(
    parameter int N_SLOTS = mbx_pkg::NUM_SLOTS,
    parameter int N_WORDS = mbx_pkg::MSG_WORDS,
    parameter int W       = mbx_pkg::DATA_W
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  rd_req,
    input  host_dec_t                             dec,
    input  logic [N_SLOTS-1:0][W-1:0]             mode_all,
    input  logic [N_SLOTS-1:0][N_WORDS-1:0][W-1:0] data_all,
    output logic [W-1:0]                          rdata
);
    logic [W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        if (dec.is_mode) begin
            rd_word = mode_all[dec.slot];
        end
        for (int w = 0; w < N_WORDS; w++) begin
            if (dec.is_data && (dec.idx == IDX_W'(w + 1))) begin
                rd_word = data_all[dec.slot][w];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_req) begin
            rdata <= rd_word;
        end
    end

    // R2: read data only moves on a read request
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(rdata));

    // R8: out-of-range words read as zero
    assert_gap_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !dec.is_mode && !dec.is_data) |=> (rdata == '0));

endmodule

// File: rtl/ipc_mailbox_bank.sv
module ipc_mailbox_bank
    import mbx_pkg::*;
#(
    parameter int N_SLOTS = mbx_pkg::NUM_SLOTS,
    parameter int N_WORDS = mbx_pkg::MSG_WORDS,
    parameter int W       = mbx_pkg::DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_en,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [W-1:0]       host_wdata,
    output logic [W-1:0]       host_rdata,
    input  logic               peer_ack_valid,
    input  logic [SLOT_W-1:0]  peer_ack_slot,
    input  logic               peer_rx_valid,
    input  logic [SLOT_W-1:0]  peer_rx_slot,
    output logic [N_SLOTS-1:0] ack_evt
);
    host_dec_t                              dec;
    logic                                   rd_req;
    logic [N_SLOTS-1:0]                     mode_we;
    logic [N_SLOTS-1:0][N_WORDS-1:0]        data_we;
    logic [N_SLOTS-1:0]                     ack_vec;
    logic [N_SLOTS-1:0]                     rx_vec;
    logic [N_SLOTS-1:0][W-1:0]              mode_all;
    logic [N_SLOTS-1:0][N_WORDS-1:0][W-1:0] data_all;

    mbx_addr_dec #(.N_SLOTS(N_SLOTS), .N_WORDS(N_WORDS)) u_dec (
        .host_en        (host_en),
        .host_we        (host_we),
        .host_addr      (host_addr),
        .peer_ack_valid (peer_ack_valid),
        .peer_ack_slot  (peer_ack_slot),
        .peer_rx_valid  (peer_rx_valid),
        .peer_rx_slot   (peer_rx_slot),
        .dec            (dec),
        .rd_req         (rd_req),
        .mode_we        (mode_we),
        .data_we        (data_we),
        .ack_vec        (ack_vec),
        .rx_vec         (rx_vec)
    );

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        mbx_slot #(.N_WORDS(N_WORDS), .W(W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .mode_we  (mode_we[s]),
            .data_we  (data_we[s]),
            .wdata    (host_wdata),
            .peer_ack (ack_vec[s]),
            .peer_rx  (rx_vec[s]),
            .mode_q   (mode_all[s]),
            .data_q   (data_all[s]),
            .ack_evt  (ack_evt[s])
        );
    end

    mbx_rd_port #(.N_SLOTS(N_SLOTS), .N_WORDS(N_WORDS), .W(W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .dec      (dec),
        .mode_all (mode_all),
        .data_all (data_all),
        .rdata    (host_rdata)
    );

    // R6: at most one slot can be acknowledged per cycle, so at most one event
    assert_single_evt_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_evt));

    // R9: acknowledge beats receive on the same slot
    assert_ack_over_rx_R9: assert property (@(posedge clk) disable iff (rst)
        (peer_ack_valid && peer_rx_valid && (peer_ack_slot == peer_rx_slot))
        |=> (mode_all[$past(peer_ack_slot)][ST_LSB +: ST_W] != ST_RX));

endmodule

// File: tb/ipc_mailbox_bank_tb_top.sv
module ipc_mailbox_bank_tb_top;
    localparam int NS = 32;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [8:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        peer_ack_valid = 1'b0;
    logic [4:0]  peer_ack_slot = '0;
    logic        peer_rx_valid = 1'b0;
    logic [4:0]  peer_rx_slot = '0;
    logic [31:0] ack_evt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ipc_mailbox_bank dut_i (
        .clk(clk), .rst(rst),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .peer_ack_valid(peer_ack_valid), .peer_ack_slot(peer_ack_slot),
        .peer_rx_valid(peer_rx_valid), .peer_rx_slot(peer_rx_slot),
        .ack_evt(ack_evt)
    );

    // behavioural reference model
    logic [31:0] m_mode [NS];
    logic [31:0] m_data [NS][NW];
    logic [31:0] m_rd;
    logic [31:0] m_evt;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int s = 0; s < NS; s++) begin
                m_mode[s] = 32'h10;
                for (int w = 0; w < NW; w++) m_data[s][w] = 32'h0;
            end
            m_rd  = 32'h0;
            m_evt = 32'h0;
        end else begin
            int s, w;
            logic [31:0] old_mode [NS];
            s = int'(host_addr[8:4]);
            w = int'(host_addr[3:0]);
            for (int k = 0; k < NS; k++) old_mode[k] = m_mode[k];
            if (host_en && !host_we) begin
                if (w == 0) m_rd = old_mode[s];
                else if (w <= NW) m_rd = m_data[s][w-1];
                else m_rd = 32'h0;
            end
            if (host_en && host_we) begin
                if (w == 0) m_mode[s] = host_wdata;
                else if (w <= NW) m_data[s][w-1] = host_wdata;
            end
            m_evt = 32'h0;
            if (peer_rx_valid && !(peer_ack_valid && peer_ack_slot == peer_rx_slot))
                m_mode[peer_rx_slot][7:4] = 4'h4;
            if (peer_ack_valid) begin
                if (old_mode[peer_ack_slot][0]) m_mode[peer_ack_slot][7:4] = 4'h1;
                else begin
                    m_mode[peer_ack_slot][7:4] = 4'h8;
                    m_evt[peer_ack_slot] = 1'b1;
                end
            end
        end
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 rdata vs model", host_rdata, m_rd);
            chk("R6 ack_evt vs model", ack_evt, m_evt);
        end
    end

    function automatic logic [8:0] wa(input int slot, input int word);
        return 9'(slot * 16 + word);
    endfunction

    task automatic cyc(input bit en, input bit we, input logic [8:0] a, input logic [31:0] d,
                       input bit av, input int as, input bit rv, input int rs);
        @(negedge clk);
        host_en = en; host_we = we; host_addr = a; host_wdata = d;
        peer_ack_valid = av; peer_ack_slot = 5'(as);
        peer_rx_valid = rv; peer_rx_slot = 5'(rs);
        @(negedge clk);
        host_en = 0; host_we = 0;
        peer_ack_valid = 0; peer_rx_valid = 0;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        cyc(1, 1, a, d, 0, 0, 0, 0);
    endtask

    task automatic rd_chk(input logic [8:0] a, input logic [31:0] exp, input string tag);
        cyc(1, 0, a, 32'h0, 0, 0, 0, 0);
        chk(tag, host_rdata, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;

        // R4 reset contents
        rd_chk(wa(0, 0),  32'h10, "R4 slot0 control after reset");
        rd_chk(wa(31, 0), 32'h10, "R4 slot31 control after reset");
        rd_chk(wa(7, 4),  32'h0,  "R4 payload after reset");
        chk("R4 ack_evt after reset", ack_evt, 32'h0);

        // R1 address map: fill slot 0 and slot 31 payloads
        for (int w = 0; w < NW; w++) wr(wa(0, w + 1), 32'hA500_0000 + 32'(w));
        for (int w = 0; w < NW; w++) wr(wa(31, w + 1), 32'h5A31_0000 + 32'(w));
        for (int w = 0; w < NW; w++) rd_chk(wa(0, w + 1), 32'hA500_0000 + 32'(w), "R1 slot0 payload");
        rd_chk(wa(31, 8), 32'h5A31_0007, "R1 slot31 last payload word");
        rd_chk(wa(1, 1), 32'h0, "R1 neighbour slot untouched");
        rd_chk(wa(0, 0), 32'h10, "R1 control word not hit by payload writes");

        // R3 full control word readback
        wr(wa(3, 0), 32'hDEAD_BE21);
        rd_chk(wa(3, 0), 32'hDEAD_BE21, "R3 control word readback");

        // R2 read data holds between reads
        repeat (3) @(negedge clk);
        chk("R2 rdata held", host_rdata, 32'hDEAD_BE21);

        // R5 automatic acknowledge
        wr(wa(4, 0), 32'h0000_0021);
        cyc(0, 0, 9'h0, 32'h0, 1, 4, 0, 0);
        chk("R5 no event in automatic mode", ack_evt, 32'h0);
        rd_chk(wa(4, 0), 32'h0000_0011, "R5 state idle after auto ack");

        // R6 interrupt acknowledge
        wr(wa(5, 0), 32'hABCD_0020);
        cyc(0, 0, 9'h0, 32'h0, 1, 5, 0, 0);
        chk("R6 event raised", ack_evt, 32'h0000_0020);
        @(negedge clk);
        chk("R6 event lasts one cycle", ack_evt, 32'h0);
        rd_chk(wa(5, 0), 32'hABCD_0080, "R6 state ack");
        wr(wa(5, 0), 32'hABCD_0010);
        rd_chk(wa(5, 0), 32'hABCD_0010, "R3 software idle write-back");

        // R7 peer receive
        wr(wa(6, 0), 32'h0000_F021);
        cyc(0, 0, 9'h0, 32'h0, 0, 0, 1, 6);
        rd_chk(wa(6, 0), 32'h0000_F041, "R7 state receive");

        // R8 gap words
        wr(wa(2, 9), 32'hFFFF_FFFF);
        wr(wa(2, 15), 32'h1234_5678);
        rd_chk(wa(2, 9), 32'h0, "R8 gap word reads zero");
        rd_chk(wa(2, 15), 32'h0, "R8 top gap word reads zero");
        rd_chk(wa(2, 0), 32'h10, "R8 control unchanged by gap write");
        rd_chk(wa(2, 8), 32'h0, "R8 payload unchanged by gap write");
        rd_chk(wa(3, 0), 32'hDEAD_BE21, "R8 next slot unchanged");

        // R9 / R10 collision: stored mode is interrupt, host writes auto
        cyc(1, 1, wa(8, 0), 32'h55AA_0021, 1, 8, 0, 0);
        chk("R10 stored interrupt mode gives event", ack_evt, 32'h0000_0100);
        rd_chk(wa(8, 0), 32'h55AA_0081, "R9 peer state wins, host bits kept");
        // stored mode is now auto, host writes interrupt
        cyc(1, 1, wa(8, 0), 32'h0000_0020, 1, 8, 0, 0);
        chk("R10 stored auto mode gives no event", ack_evt, 32'h0);
        rd_chk(wa(8, 0), 32'h0000_0010, "R10 idle after auto ack");

        // R9 ack beats receive on the same slot
        wr(wa(9, 0), 32'h0000_0021);
        cyc(0, 0, 9'h0, 32'h0, 1, 9, 1, 9);
        rd_chk(wa(9, 0), 32'h0000_0011, "R9 ack wins over receive");

        // R6/R7 different slots at once, slot 31 boundary
        cyc(0, 0, 9'h0, 32'h0, 1, 31, 1, 30);
        chk("R6 event on slot 31", ack_evt, 32'h8000_0000);
        rd_chk(wa(31, 0), 32'h0000_0080, "R6 slot31 state ack");
        rd_chk(wa(30, 0), 32'h0000_0040, "R7 slot30 state receive");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule